// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block sits between a byte-wide host bus and one UART channel. The host bus has a 3-bit address, a chip select and separate read and write strobes. The block turns each access into a read of, or a write to, one entry of a banked register file. Eight addresses are not enough for the channel's registers, so stored mode bits choose which register an address reaches. Those mode bits are the divisor-access bit of the line control register, a key value written into that same register, and an enable pair made of one bit in the feature register and one bit in the modem control register.

The block stores the control registers and drives them out as plain outputs for the rest of the channel: line control, modem control, interrupt enable, feature, scratch, 16-bit divisor, four flow-control characters, transmission control and trigger level. The transmit and receive holding registers, the line and modem status, the interrupt identification code and the FIFO fill flags all live elsewhere. The block reaches them only through single-cycle strobes and read-path inputs.

No data stream crosses this block, so it has no valid/ready handshake. Every pin is a plain control or status signal. Reads are combinational from the address in the cycle the read strobe is high. Writes land on the rising clock edge.

Top module: `uart_regbank_decoder`

## Requirements
- R1: After reset, every stored register reads back 0x00. `rdata` is 0x00 whenever `cs` or `rd` is low.
- R2: With LCR bit 7 = 0 and no enable pair active, addresses 0..7 read holding, IER, IIR, LCR, MCR, LSR (`lsr_in`), MSR (`msr_in`) and scratch. A write to address 7 stores the scratch byte.
- R3: With LCR bit 7 = 1, address 0 reaches divisor bits 7:0 and address 1 reaches divisor bits 15:8, for both read and write. A write to address 0 in this mode does not raise `thr_we`.
- R4: When LCR equals 0xBF, address 2 reaches the feature register, and addresses 4, 5, 6 and 7 reach XON1, XON2, XOFF1 and XOFF2. Addresses 0, 1 and 3 still reach the divisor and LCR. A write to address 2 in this mode does not raise `fcr_we`.
- R5: When feature bit 4 = 1, MCR bit 6 = 1 and LCR is not 0xBF, address 6 reaches TCR and address 7 reaches TLR. These replace MSR and scratch.
- R6: A read at address 7 that would reach scratch instead returns {2'b00, `rx_rdy`[1:0], 2'b00, `tx_rdy`[1:0]}. This happens when MCR bit 2 = 1 and MCR bit 4 = 0.
- R7: While feature bit 4 = 0, writes leave MCR bits 7:5 and IER bits 7:4 unchanged. The lower bits of both registers are still written.
- R8: An IIR read returns the stored FIFO-enable bit on bits 7 and 6, and `iir_code` on bits 5:0. The FIFO-enable bit is FCR bit 0, captured on each write to address 2 in a bank where that address is FCR.
- R9: `thr_we`, `fcr_we` and `rhr_re` are combinational and high only during the access that selects them. At most one of `thr_we` and `fcr_we` is high at a time.
- R10: A write changes register contents only at the clock edge. A read in the same cycle as a bank-switching LCR write returns the value from before the write, and the following access decodes in the new bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| rhr_data | input | 8 | Receive holding byte from the receive FIFO |
| lsr_in | input | 8 | Line status word |
| msr_in | input | 8 | Modem status word |
| iir_code | input | 6 | Interrupt identification bits 5:0 |
| rx_rdy | input | 2 | Receive FIFO ready flags, channel B in bit 1 |
| tx_rdy | input | 2 | Transmit FIFO ready flags, channel B in bit 1 |
| rhr_re | output | 1 | Pop strobe for the receive holding register |
| thr_we | output | 1 | Push strobe for the transmit holding register |
| fcr_we | output | 1 | FIFO control write strobe, data on wdata |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| ier_o | output | 8 | Interrupt enable register |
| efr_o | output | 8 | Feature register |
| dl_o | output | 16 | Divisor |
| xon1_o | output | 8 | XON1 character |
| xon2_o | output | 8 | XON2 character |
| xoff1_o | output | 8 | XOFF1 character |
| xoff2_o | output | 8 | XOFF2 character |
| tcr_o | output | 8 | Transmission control register |
| tlr_o | output | 8 | Trigger level register |
| fifo_en_o | output | 1 | Stored FIFO-enable bit |

## Verification
The two functions that can fall in the same cycle are the combinational read decode and a write that moves LCR into a different bank. The bench raises `rd` and `wr` together at address 3 while writing 0xBF. It expects `rdata` to still show the old LCR during that cycle, and the next read at address 2 to return the feature register, not IIR. The enable-gated writes are a second overlap: the lower bits of MCR and IER change while the upper bits are held. The bench judges this by reading both registers back through the bus, first with feature bit 4 clear and then with it set.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [4:0] {
    RS_HOLD, RS_IER, RS_IIR_FCR, RS_LCR, RS_MCR, RS_LSR, RS_MSR, RS_SPR,
    RS_DLL, RS_DLM, RS_EFR, RS_XON1, RS_XON2, RS_XOFF1, RS_XOFF2,
    RS_TCR, RS_TLR
  } rsel_e;

  typedef struct packed {
    logic [DATA_W-1:0] lcr;
    logic [DATA_W-1:0] mcr;
    logic [DATA_W-1:0] ier;
    logic [DATA_W-1:0] efr;
    logic [DATA_W-1:0] spr;
    logic [DATA_W-1:0] dll;
    logic [DATA_W-1:0] dlm;
    logic [DATA_W-1:0] tcr;
    logic [DATA_W-1:0] tlr;
    logic              fifo_en;
  } regfile_t;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
#(
  parameter logic [DATA_W-1:0] ENH_KEY = 8'hBF,
  parameter int DLAB_BIT = 7,
  parameter int EN_EFR_BIT = 4,
  parameter int EN_MCR_BIT = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] lcr,
  input  logic [DATA_W-1:0] efr,
  input  logic [DATA_W-1:0] mcr,
  output rsel_e             sel
);
  logic in_enh, in_div, in_tt;
  rsel_e gen_sel;

  assign in_enh = (lcr == ENH_KEY);
  assign in_div = lcr[DLAB_BIT];
  assign in_tt  = efr[EN_EFR_BIT] & mcr[EN_MCR_BIT];

  always_comb begin
    case (addr)
      3'd0:    gen_sel = RS_HOLD;
      3'd1:    gen_sel = RS_IER;
      3'd2:    gen_sel = RS_IIR_FCR;
      3'd3:    gen_sel = RS_LCR;
      3'd4:    gen_sel = RS_MCR;
      3'd5:    gen_sel = RS_LSR;
      3'd6:    gen_sel = RS_MSR;
      default: gen_sel = RS_SPR;
    endcase
  end

  always_comb begin
    sel = gen_sel;
    // lowest priority first; later statements win
    if (in_tt && addr == 3'd6) sel = RS_TCR;
    if (in_tt && addr == 3'd7) sel = RS_TLR;
    if (in_div && addr == 3'd0) sel = RS_DLL;
    if (in_div && addr == 3'd1) sel = RS_DLM;
    if (in_enh) begin
      case (addr)
        3'd2: sel = RS_EFR;
        3'd4: sel = RS_XON1;
        3'd5: sel = RS_XON2;
        3'd6: sel = RS_XOFF1;
        3'd7: sel = RS_XOFF2;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
  import uart_rb_pkg::*;
#(
  parameter int N_FC = 4,
  parameter int GATE_EFR_BIT = 4,
  parameter int MCR_OPEN_W = 5,
  parameter int IER_OPEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  rsel_e             sel,
  input  logic [DATA_W-1:0] wdata,
  output regfile_t          rf,
  output logic [DATA_W-1:0] fc_chr [N_FC]
);
  logic enh_ok;
  logic [DATA_W-1:0] mcr_mask, ier_mask;

  assign enh_ok   = rf.efr[GATE_EFR_BIT];
  assign mcr_mask = enh_ok ? '1 : DATA_W'((1 << MCR_OPEN_W) - 1);
  assign ier_mask = enh_ok ? '1 : DATA_W'((1 << IER_OPEN_W) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf <= '0;
    end else if (we) begin
      case (sel)
        RS_LCR:     rf.lcr <= wdata;
        RS_MCR:     rf.mcr <= (wdata & mcr_mask) | (rf.mcr & ~mcr_mask);
        RS_IER:     rf.ier <= (wdata & ier_mask) | (rf.ier & ~ier_mask);
        RS_EFR:     rf.efr <= wdata;
        RS_SPR:     rf.spr <= wdata;
        RS_DLL:     rf.dll <= wdata;
        RS_DLM:     rf.dlm <= wdata;
        RS_TCR:     rf.tcr <= wdata;
        RS_TLR:     rf.tlr <= wdata;
        RS_IIR_FCR: rf.fifo_en <= wdata[0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_FC; g++) begin : g_fc
    rsel_e my_sel;
    assign my_sel = rsel_e'(int'(RS_XON1) + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     fc_chr[g] <= '0;
      else if (we && sel == my_sel)   fc_chr[g] <= wdata;
    end
  end
endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
  import uart_rb_pkg::*;
#(
  parameter int N_FC = 4,
  parameter int CH_N = 2,
  parameter int RDY_EN_BIT = 2,
  parameter int LOOP_BIT = 4
) (
  input  logic              rd_act,
  input  rsel_e             sel,
  input  regfile_t          rf,
  input  logic [DATA_W-1:0] fc_chr [N_FC],
  input  logic [DATA_W-1:0] rhr_data,
  input  logic [DATA_W-1:0] lsr_in,
  input  logic [DATA_W-1:0] msr_in,
  input  logic [5:0]        iir_code,
  input  logic [CH_N-1:0]   rx_rdy,
  input  logic [CH_N-1:0]   tx_rdy,
  output logic [DATA_W-1:0] rdata
);
  localparam int HALF = DATA_W / 2;
  logic [DATA_W-1:0] rdy_word, mux;
  logic rdy_vis;

  assign rdy_vis = rf.mcr[RDY_EN_BIT] & ~rf.mcr[LOOP_BIT];

  always_comb begin
    rdy_word = '0;
    rdy_word[HALF +: CH_N] = rx_rdy;
    rdy_word[0 +: CH_N]    = tx_rdy;
  end

  always_comb begin
    case (sel)
      RS_HOLD:    mux = rhr_data;
      RS_IER:     mux = rf.ier;
      RS_IIR_FCR: mux = {{2{rf.fifo_en}}, iir_code};
      RS_LCR:     mux = rf.lcr;
      RS_MCR:     mux = rf.mcr;
      RS_LSR:     mux = lsr_in;
      RS_MSR:     mux = msr_in;
      RS_SPR:     mux = rdy_vis ? rdy_word : rf.spr;
      RS_DLL:     mux = rf.dll;
      RS_DLM:     mux = rf.dlm;
      RS_EFR:     mux = rf.efr;
      RS_XON1:    mux = fc_chr[0];
      RS_XON2:    mux = fc_chr[1];
      RS_XOFF1:   mux = fc_chr[2];
      RS_XOFF2:   mux = fc_chr[3];
      RS_TCR:     mux = rf.tcr;
      RS_TLR:     mux = rf.tlr;
      default:    mux = '0;
    endcase
  end

  assign rdata = rd_act ? mux : '0;
endmodule

// File: rtl/uart_regbank_decoder.sv
module uart_regbank_decoder
  import uart_rb_pkg::*;
#(
  parameter int CH_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        rhr_data,
  input  logic [7:0]        lsr_in,
  input  logic [7:0]        msr_in,
  input  logic [5:0]        iir_code,
  input  logic [CH_N-1:0]   rx_rdy,
  input  logic [CH_N-1:0]   tx_rdy,
  output logic              rhr_re,
  output logic              thr_we,
  output logic              fcr_we,
  output logic [7:0]        lcr_o,
  output logic [7:0]        mcr_o,
  output logic [7:0]        ier_o,
  output logic [7:0]        efr_o,
  output logic [15:0]       dl_o,
  output logic [7:0]        xon1_o,
  output logic [7:0]        xon2_o,
  output logic [7:0]        xoff1_o,
  output logic [7:0]        xoff2_o,
  output logic [7:0]        tcr_o,
  output logic [7:0]        tlr_o,
  output logic              fifo_en_o
);
  localparam int N_FC = 4;

  rsel_e             sel;
  regfile_t          rf;
  logic [DATA_W-1:0] fc_chr [N_FC];
  logic              we, rd_act;

  assign we     = cs & wr;
  assign rd_act = cs & rd;

  uart_rb_decode u_dec (
    .addr (addr), .lcr (rf.lcr), .efr (rf.efr), .mcr (rf.mcr), .sel (sel)
  );

  uart_rb_regs #(.N_FC(N_FC)) u_regs (
    .clk (clk), .rst_n (rst_n), .we (we), .sel (sel), .wdata (wdata),
    .rf (rf), .fc_chr (fc_chr)
  );

  uart_rb_rdmux #(.N_FC(N_FC), .CH_N(CH_N)) u_rd (
    .rd_act (rd_act), .sel (sel), .rf (rf), .fc_chr (fc_chr),
    .rhr_data (rhr_data), .lsr_in (lsr_in), .msr_in (msr_in),
    .iir_code (iir_code), .rx_rdy (rx_rdy), .tx_rdy (tx_rdy),
    .rdata (rdata)
  );

  assign rhr_re = rd_act & (sel == RS_HOLD);
  assign thr_we = we & (sel == RS_HOLD);
  assign fcr_we = we & (sel == RS_IIR_FCR);

  assign lcr_o     = rf.lcr;
  assign mcr_o     = rf.mcr;
  assign ier_o     = rf.ier;
  assign efr_o     = rf.efr;
  assign dl_o      = {rf.dlm, rf.dll};
  assign xon1_o    = fc_chr[0];
  assign xon2_o    = fc_chr[1];
  assign xoff1_o   = fc_chr[2];
  assign xoff2_o   = fc_chr[3];
  assign tcr_o     = rf.tcr;
  assign tlr_o     = rf.tlr;
  assign fifo_en_o = rf.fifo_en;
endmodule

// File: rtl/uart_regbank_decoder_chk.sv
module uart_regbank_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs,
  input logic        rd,
  input logic        wr,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        rhr_re,
  input logic        thr_we,
  input logic        fcr_we,
  input logic [7:0]  lcr_o,
  input logic [7:0]  mcr_o,
  input logic [7:0]  ier_o,
  input logic [7:0]  efr_o,
  input logic [15:0] dl_o,
  input logic [7:0]  tcr_o,
  input logic        fifo_en_o
);
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> rdata == 8'h00); // R1
  AST_DIV_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && lcr_o[7] && addr == 3'd0) |=> dl_o[7:0] == $past(wdata)); // R3
  AST_NO_THR_IN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_o[7] |-> !thr_we); // R3
  AST_EFR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && lcr_o == 8'hBF && addr == 3'd2) |=> efr_o == $past(wdata)); // R4
  AST_TCR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && lcr_o != 8'hBF && efr_o[4] && mcr_o[6] && addr == 3'd6)
    |=> tcr_o == $past(wdata)); // R5
  AST_RDY_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == 3'd7 && !lcr_o[7] && !(efr_o[4] && mcr_o[6])
     && mcr_o[2] && !mcr_o[4]) |-> (rdata[7:6] == 2'b00 && rdata[3:2] == 2'b00)); // R6
  AST_MCR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_o[4] |=> mcr_o[7:5] == $past(mcr_o[7:5])); // R7
  AST_IER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_o[4] |=> ier_o[7:4] == $past(ier_o[7:4])); // R7
  AST_IIR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == 3'd2 && lcr_o != 8'hBF) |-> rdata[7:6] == {2{fifo_en_o}}); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({thr_we, fcr_we})); // R9
  AST_THR_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |-> (cs && wr && addr == 3'd0)); // R9
  AST_RHR_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rhr_re |-> (cs && rd && addr == 3'd0 && !lcr_o[7])); // R9
  AST_LCR_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr && addr == 3'd3) |=> $stable(lcr_o)); // R10
endmodule

bind uart_regbank_decoder uart_regbank_decoder_chk u_chk (
  .clk (clk), .rst_n (rst_n), .cs (cs), .rd (rd), .wr (wr), .addr (addr),
  .wdata (wdata), .rdata (rdata), .rhr_re (rhr_re), .thr_we (thr_we),
  .fcr_we (fcr_we), .lcr_o (lcr_o), .mcr_o (mcr_o), .ier_o (ier_o),
  .efr_o (efr_o), .dl_o (dl_o), .tcr_o (tcr_o), .fifo_en_o (fifo_en_o)
);

// File: tb/uart_regbank_decoder_bench.sv
module uart_regbank_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata, rhr_data = '0, lsr_in = '0, msr_in = '0;
  logic [5:0] iir_code = '0;
  logic [1:0] rx_rdy = '0, tx_rdy = '0;
  logic rhr_re, thr_we, fcr_we, fifo_en_o;
  logic [7:0] lcr_o, mcr_o, ier_o, efr_o, xon1_o, xon2_o, xoff1_o, xoff2_o, tcr_o, tlr_o;
  logic [15:0] dl_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank_decoder u_uart_regbank_decoder (
    .clk, .rst_n, .cs, .rd, .wr, .addr, .wdata, .rdata, .rhr_data, .lsr_in,
    .msr_in, .iir_code, .rx_rdy, .tx_rdy, .rhr_re, .thr_we, .fcr_we,
    .lcr_o, .mcr_o, .ier_o, .efr_o, .dl_o, .xon1_o, .xon2_o, .xoff1_o,
    .xoff2_o, .tcr_o, .tlr_o, .fifo_en_o
  );

  typedef struct {
    string      tag;
    logic [7:0] exp_rd;
    logic [2:0] exp_strb;
  } item_t;

  item_t sb_q[$];
  event  smp;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // monitor: strobes vector is {rhr_re, thr_we, fcr_we}
  initial forever begin
    @(smp);
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (rdata !== it.exp_rd || {rhr_re, thr_we, fcr_we} !== it.exp_strb) begin
        n_fail++;
        $display("FAIL %s: rdata=%h strb=%b expected rdata=%h strb=%b",
                 it.tag, rdata, {rhr_re, thr_we, fcr_we}, it.exp_rd, it.exp_strb);
      end
    end
  end

  task automatic access(input bit r, input bit w, input logic [2:0] a,
                        input logic [7:0] d, input logic [7:0] e_rd,
                        input logic [2:0] e_strb, input string tag);
    item_t it;
    @(negedge clk);
    cs = 1; rd = r; wr = w; addr = a; wdata = d;
    it.tag = tag; it.exp_rd = e_rd; it.exp_strb = e_strb;
    sb_q.push_back(it);
    #1 -> smp;
    @(posedge clk);
    #1 cs = 0; rd = 0; wr = 0;
  endtask

  task automatic rchk(input logic [2:0] a, input logic [7:0] e, input string tag);
    access(1, 0, a, 8'h00, e, (a == 3'd0 && e === rhr_data && !lcr_o[7]) ? 3'b100 : 3'b000, tag);
  endtask

  task automatic wput(input logic [2:0] a, input logic [7:0] d, input logic [2:0] e_strb,
                      input string tag);
    access(0, 1, a, d, 8'h00, e_strb, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset values and idle bus
    rchk(3'd3, 8'h00, "R1 LCR reset");
    rchk(3'd4, 8'h00, "R1 MCR reset");
    rchk(3'd1, 8'h00, "R1 IER reset");
    rchk(3'd7, 8'h00, "R1 SPR reset");
    lsr_in = 8'h61;
    access(0, 0, 3'd5, 8'h00, 8'h00, 3'b000, "R1 rdata zero without rd");
    // R2: general set
    msr_in = 8'hB2; rhr_data = 8'h3C;
    wput(3'd7, 8'h5A, 3'b000, "R2 SPR write");
    rchk(3'd7, 8'h5A, "R2 SPR read");
    access(1, 0, 3'd0, 8'h00, 8'h3C, 3'b100, "R2 RHR read r9_pop");
    wput(3'd0, 8'hA5, 3'b010, "R9 THR write strobe");
    rchk(3'd5, 8'h61, "R2 LSR read");
    rchk(3'd6, 8'hB2, "R2 MSR read");
    // R7: protected bits while feature bit 4 clear
    wput(3'd4, 8'hE3, 3'b000, "R7 MCR write locked");
    rchk(3'd4, 8'h03, "R7 MCR upper held");
    wput(3'd1, 8'hFF, 3'b000, "R7 IER write locked");
    rchk(3'd1, 8'h0F, "R7 IER upper held");
    // R8: IIR mirror
    iir_code = 6'h0C;
    wput(3'd2, 8'h01, 3'b001, "R8 FCR enable write");
    rchk(3'd2, 8'hCC, "R8 IIR with fifo enabled");
    wput(3'd2, 8'h00, 3'b001, "R8 FCR disable write");
    rchk(3'd2, 8'h0C, "R8 IIR with fifo disabled");
    // R3: divisor bank
    wput(3'd3, 8'h80, 3'b000, "R3 LCR dlab");
    wput(3'd0, 8'h34, 3'b000, "R3 DLL write no thr_we");
    wput(3'd1, 8'h12, 3'b000, "R3 DLM write");
    rchk(3'd0, 8'h34, "R3 DLL read");
    rchk(3'd1, 8'h12, "R3 DLM read");
    rchk(3'd5, 8'h61, "R3 LSR falls through");
    wput(3'd2, 8'h00, 3'b001, "R9 FCR strobe in dlab bank");
    // R10: read during bank-switching write sees old value
    access(1, 1, 3'd3, 8'hBF, 8'h80, 3'b000, "R10 same-cycle read old LCR");
    rchk(3'd2, 8'h00, "R10 next access in enhanced bank");
    // R4: enhanced bank
    wput(3'd2, 8'h10, 3'b000, "R4 EFR write no fcr_we");
    wput(3'd4, 8'h11, 3'b000, "R4 XON1 write");
    wput(3'd5, 8'h13, 3'b000, "R4 XON2 write");
    wput(3'd6, 8'h91, 3'b000, "R4 XOFF1 write");
    wput(3'd7, 8'h93, 3'b000, "R4 XOFF2 write");
    rchk(3'd2, 8'h10, "R4 EFR read");
    rchk(3'd4, 8'h11, "R4 XON1 read");
    rchk(3'd5, 8'h13, "R4 XON2 read");
    rchk(3'd6, 8'h91, "R4 XOFF1 read");
    rchk(3'd7, 8'h93, "R4 XOFF2 read");
    rchk(3'd0, 8'h34, "R4 DLL still reachable");
    rchk(3'd3, 8'hBF, "R4 LCR still reachable");
    // R7: enhanced enabled, upper bits now writable
    wput(3'd3, 8'h03, 3'b000, "R2 LCR back to general");
    wput(3'd4, 8'hE3, 3'b000, "R7 MCR write unlocked");
    rchk(3'd4, 8'hE3, "R7 MCR upper written");
    wput(3'd1, 8'hF5, 3'b000, "R7 IER write unlocked");
    rchk(3'd1, 8'hF5, "R7 IER upper written");
    // R5: TCR/TLR
    wput(3'd6, 8'h2A, 3'b000, "R5 TCR write");
    wput(3'd7, 8'h4B, 3'b000, "R5 TLR write");
    rchk(3'd6, 8'h2A, "R5 TCR read replaces MSR");
    rchk(3'd7, 8'h4B, "R5 TLR read replaces SPR");
    // R6: FIFO ready word
    rx_rdy = 2'b10; tx_rdy = 2'b01;
    wput(3'd4, 8'h04, 3'b000, "R6 MCR ready enable");
    rchk(3'd7, 8'h21, "R6 ready word layout");
    wput(3'd4, 8'h14, 3'b000, "R6 MCR loopback");
    rchk(3'd7, 8'h5A, "R6 loopback hides ready word");
    rchk(3'd6, 8'hB2, "R5 MSR back when enable pair off");
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule